// File: doc/BRIEF.md
# Race-Logic Weighted Edit-Distance Array

This block scores the similarity of two nucleotide strings by racing a single pulse through a square grid of cells instead of adding and comparing numbers. Each cell stands for one entry of the edit-distance table. After `start`, the origin cell fires. Every fired cell then sends its pulse right, down and diagonally, each through a delay chain whose length in clock cycles equals the cost of that edit. The score is the count of cycles until the far corner cell fires. A free-running counter measures that time, and the block reports it on `score` with a one-cycle `done`.

In minimise mode a cell fires as soon as any of its incoming pulses arrives, which is an OR of its inputs, so the corner time is the cheapest edit path. In maximise mode a cell waits until every incoming pulse has arrived, which is an AND of its inputs, so the corner time is the most expensive path. Cells are grouped into bands of rows. A band is only clocked while the wavefront can change something in it. It stays disabled until a cell in the band above has fired, and it is disabled again once all of its cells and delay chains are saturated.

The control is a two-state machine. `S_IDLE` waits. The transition *launch* (`start`) enters `S_RACE`. In `S_RACE`, the transition *relaunch* (`start` again) stays in `S_RACE` and restarts the race, and the transition *finish* (the corner cell has fired) returns to `S_IDLE`.

Top module: `race_edit_distance`

## Requirements
- R1: A `start` pulse captures both strings and the mode, clears every cell, fires the origin cell and restarts the cycle counter at 0. This also holds when `start` arrives while a race is running.
- R2: Symbol k of a string sits at bits [2k+1:2k], with k=0 the first symbol, coded A=00, C=01, G=10, T=11. A diagonal step costs the match cost when its two symbols are equal and the substitution cost otherwise.
- R3: With `mode_max`=0 the score is the minimum-cost path from the origin to the corner. A horizontal step costs the insertion cost and a vertical step costs the deletion cost. With the defaults match=1, insertion=1, deletion=1, substitution=2, the strings ACGTGCA and CCTGCAA score exactly that minimum.
- R4: With `mode_max`=1 the score is the maximum-cost path from the origin to the corner under the same step costs.
- R5: `done` is high for exactly one cycle, score+1 clock edges after the edge that sampled `start`, and `score` carries the result in that cycle.
- R6: After reset `done` and `score` are 0. `score` keeps its value between `done` pulses.
- R7: Changes of the strings or of `mode_max` after the `start` edge do not affect the running race.
- R8: With region gating enabled, the score is the same path cost as in R3 and R4.
- R9: A fired cell stays fired until the next `start`.
- R10: During a race the counter never exceeds 2·N times the largest cost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture the inputs and launch a race |
| mode_max | input | 1 | 0 = minimise (OR), 1 = maximise (AND) |
| str_a | input | 2*N | Row string, 2 bits per symbol |
| str_b | input | 2*N | Column string, 2 bits per symbol |
| done | output | 1 | One-cycle result strobe |
| score | output | SCORE_W | Corner arrival cycle of the last race |

## Verification
The bench builds the array with N=7, the default costs (1, 1, 1, 2) and three rows per region. The seven-symbol example therefore fits exactly, and the 8-row grid splits into bands of 3, 3 and 2 rows, so the short last band is also gated. The substitution cost of 2 makes the diagonal delay chain choose between two taps, which exercises the symbol comparison in both directions. With strings of seven symbols, scores stay small enough to cover identical, fully different and random strings in both modes well inside the run length.

// File: rtl/rl_pkg.sv
package rl_pkg;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_RACE = 1'b1
    } race_state_t;

    localparam int DIR_UP   = 0;
    localparam int DIR_LEFT = 1;
    localparam int DIR_DIAG = 2;
    localparam int NUM_DIRS = 3;

    function automatic int max_cost(input int c0, input int c1, input int c2, input int c3);
        int m;
        m = c0;
        if (c1 > m) m = c1;
        if (c2 > m) m = c2;
        if (c3 > m) m = c3;
        return m;
    endfunction

endpackage

// File: rtl/rl_cell.sv
module rl_cell #(
    parameter int TAPS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            seed,
    input  logic            en,
    input  logic            mode_max,
    input  logic [2:0]      in_exist,
    input  logic [2:0]      in_arr,
    output logic [TAPS-1:0] tap
);

    logic fired_q;
    logic any_arr;
    logic all_arr;
    logic fire_now;

    always_comb begin
        any_arr  = |(in_arr & in_exist);
        all_arr  = (|in_exist) && ((in_arr | ~in_exist) == 3'b111);
        fire_now = mode_max ? all_arr : any_arr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     fired_q <= 1'b0;
        else if (clear) fired_q <= seed;
        else if (en)    fired_q <= fired_q | fire_now;
    end

    assign tap[0] = fired_q;

    generate
        if (TAPS > 1) begin : g_hist
            logic [TAPS-2:0] hist_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    hist_q <= '0;
                end else if (clear) begin
                    hist_q <= '0;
                end else if (en) begin
                    hist_q[0] <= fired_q;
                    for (int k = 1; k < TAPS - 1; k++) hist_q[k] <= hist_q[k-1];
                end
            end
            assign tap[TAPS-1:1] = hist_q;
        end
    endgenerate

endmodule

// File: rtl/rl_grid.sv
module rl_grid
    import rl_pkg::*;
#(
    parameter int N               = 8,
    parameter int C_MATCH         = 1,
    parameter int C_SUB           = 2,
    parameter int C_INS           = 1,
    parameter int C_DEL           = 1,
    parameter int ROWS_PER_REGION = 3,
    parameter bit GATE_REGIONS    = 1'b1,
    parameter int TAPS            = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           mode_max,
    input  logic [2*N-1:0] row_syms,
    input  logic [2*N-1:0] col_syms,
    output logic           origin_fired,
    output logic           corner_fired
);

    localparam int SIDE  = N + 1;
    localparam int NODES = SIDE * SIDE;
    localparam int NREG  = (SIDE + ROWS_PER_REGION - 1) / ROWS_PER_REGION;

    logic [TAPS-1:0] tap [NODES];
    logic [NREG-1:0] reg_any;
    logic [NREG-1:0] reg_settled;
    logic [NREG-1:0] reg_en;

    always_comb begin
        reg_any     = '0;
        reg_settled = '1;
        for (int n = 0; n < NODES; n++) begin
            reg_any[(n / SIDE) / ROWS_PER_REGION]     |= tap[n][0];
            reg_settled[(n / SIDE) / ROWS_PER_REGION] &= tap[n][TAPS-1];
        end
    end

    generate
        for (genvar b = 0; b < NREG; b++) begin : g_region
            if (!GATE_REGIONS) begin : g_free
                assign reg_en[b] = 1'b1;
            end else if (b == 0) begin : g_first
                assign reg_en[b] = !reg_settled[b];
            end else begin : g_next
                assign reg_en[b] = reg_any[b-1] && !reg_settled[b];
            end
        end

        for (genvar i = 0; i < SIDE; i++) begin : g_row
            for (genvar j = 0; j < SIDE; j++) begin : g_col
                logic [2:0] exist;
                logic [2:0] arr;

                if (i > 0) begin : g_up
                    assign exist[DIR_UP] = 1'b1;
                    assign arr[DIR_UP]   = tap[(i-1)*SIDE + j][C_DEL-1];
                end else begin : g_no_up
                    assign exist[DIR_UP] = 1'b0;
                    assign arr[DIR_UP]   = 1'b0;
                end

                if (j > 0) begin : g_left
                    assign exist[DIR_LEFT] = 1'b1;
                    assign arr[DIR_LEFT]   = tap[i*SIDE + j - 1][C_INS-1];
                end else begin : g_no_left
                    assign exist[DIR_LEFT] = 1'b0;
                    assign arr[DIR_LEFT]   = 1'b0;
                end

                if (i > 0 && j > 0) begin : g_diag
                    logic same;
                    assign same           = (row_syms[2*(i-1) +: 2] == col_syms[2*(j-1) +: 2]);
                    assign exist[DIR_DIAG] = 1'b1;
                    assign arr[DIR_DIAG]   = same ? tap[(i-1)*SIDE + j - 1][C_MATCH-1]
                                                  : tap[(i-1)*SIDE + j - 1][C_SUB-1];
                end else begin : g_no_diag
                    assign exist[DIR_DIAG] = 1'b0;
                    assign arr[DIR_DIAG]   = 1'b0;
                end

                rl_cell #(.TAPS(TAPS)) u_cell (
                    .clk      (clk),
                    .rst_n    (rst_n),
                    .clear    (clear),
                    .seed     ((i == 0 && j == 0) ? 1'b1 : 1'b0),
                    .en       (reg_en[i / ROWS_PER_REGION]),
                    .mode_max (mode_max),
                    .in_exist (exist),
                    .in_arr   (arr),
                    .tap      (tap[i*SIDE + j])
                );
            end
        end
    endgenerate

    assign origin_fired = tap[0][0];
    assign corner_fired = tap[NODES-1][0];

endmodule

// File: rtl/race_edit_distance.sv
module race_edit_distance
    import rl_pkg::*;
#(
    parameter int N               = 8,
    parameter int C_MATCH         = 1,
    parameter int C_SUB           = 2,
    parameter int C_INS           = 1,
    parameter int C_DEL           = 1,
    parameter int ROWS_PER_REGION = 3,
    parameter bit GATE_REGIONS    = 1'b1,
    parameter int SCORE_W         = $clog2(2 * N * max_cost(C_MATCH, C_SUB, C_INS, C_DEL) + 1) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               mode_max,
    input  logic [2*N-1:0]     str_a,
    input  logic [2*N-1:0]     str_b,
    output logic               done,
    output logic [SCORE_W-1:0] score
);

    localparam int TAPS      = max_cost(C_MATCH, C_SUB, C_INS, C_DEL);
    localparam int MAX_SCORE = 2 * N * TAPS;

    race_state_t        state_q, state_d;
    logic [2*N-1:0]     a_q, b_q;
    logic               mode_q;
    logic [SCORE_W-1:0] cnt_q;
    logic               corner_fired;
    logic               origin_fired;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start) state_d = S_RACE;
            S_RACE: begin
                if (start)             state_d = S_RACE;
                else if (corner_fired) state_d = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            mode_q <= 1'b0;
            cnt_q  <= '0;
            done   <= 1'b0;
            score  <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                a_q    <= str_a;
                b_q    <= str_b;
                mode_q <= mode_max;
                cnt_q  <= '0;
            end else if (state_q == S_RACE) begin
                if (corner_fired) begin
                    done  <= 1'b1;
                    score <= cnt_q;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    rl_grid #(
        .N               (N),
        .C_MATCH         (C_MATCH),
        .C_SUB           (C_SUB),
        .C_INS           (C_INS),
        .C_DEL           (C_DEL),
        .ROWS_PER_REGION (ROWS_PER_REGION),
        .GATE_REGIONS    (GATE_REGIONS),
        .TAPS            (TAPS)
    ) u_grid (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (start),
        .mode_max     (mode_q),
        .row_syms     (a_q),
        .col_syms     (b_q),
        .origin_fired (origin_fired),
        .corner_fired (corner_fired)
    );

endmodule

// File: rtl/rl_checker.sv
module rl_checker #(
    parameter int SCORE_W   = 6,
    parameter int MAX_SCORE = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               done,
    input logic               in_race,
    input logic               corner,
    input logic               origin,
    input logic [SCORE_W-1:0] cnt,
    input logic [SCORE_W-1:0] score
);

    // R1: launch fires the origin and zeroes the counter
    a_r1_launch: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (origin && in_race && cnt == '0));

    // R5: corner arrival is reported on the next cycle with the counter value
    a_r5_report: assert property (@(posedge clk) disable iff (!rst_n)
        (in_race && corner && !start) |=> (done && score == $past(cnt)));

    // R5: done is a single-cycle strobe
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: done only follows a race
    a_r5_done_after_race: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(in_race));

    // R6: score only changes together with done
    a_r6_score_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(score));

    // R9: corner cell only drops on a new launch
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(corner) |-> $past(start));

    // R10: counter stays within the largest possible path cost
    a_r10_bound: assert property (@(posedge clk) disable iff (!rst_n)
        in_race |-> (cnt <= SCORE_W'(MAX_SCORE)));

endmodule

bind race_edit_distance rl_checker #(
    .SCORE_W   (SCORE_W),
    .MAX_SCORE (MAX_SCORE)
) u_rl_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .done    (done),
    .in_race (state_q == rl_pkg::S_RACE),
    .corner  (corner_fired),
    .origin  (origin_fired),
    .cnt     (cnt_q),
    .score   (score)
);

// File: tb/race_edit_distance_bench.sv
`timescale 1ns/1ps
module race_edit_distance_bench;

    localparam int N   = 7;
    localparam int CM  = 1;
    localparam int CS  = 2;
    localparam int CI  = 1;
    localparam int CD  = 1;
    localparam int RPR = 3;
    localparam int SW  = $clog2(2 * N * 2 + 1) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          mode_max = 1'b0;
    logic [2*N-1:0] str_a = '0;
    logic [2*N-1:0] str_b = '0;
    logic          done;
    logic [SW-1:0] score;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    race_edit_distance #(
        .N(N), .C_MATCH(CM), .C_SUB(CS), .C_INS(CI), .C_DEL(CD),
        .ROWS_PER_REGION(RPR), .GATE_REGIONS(1'b1), .SCORE_W(SW)
    ) u_race_edit_distance (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_max(mode_max),
        .str_a(str_a), .str_b(str_b), .done(done), .score(score)
    );

    // A=00 C=01 G=10 T=11, symbol k at bits [2k+1:2k] (R2)
    function automatic logic [2*N-1:0] enc(input string s);
        logic [2*N-1:0] v = '0;
        for (int k = 0; k < N; k++) begin
            case (s[k])
                "A": v[2*k +: 2] = 2'b00;
                "C": v[2*k +: 2] = 2'b01;
                "G": v[2*k +: 2] = 2'b10;
                default: v[2*k +: 2] = 2'b11;
            endcase
        end
        return v;
    endfunction

    function automatic int ref_score(input logic [2*N-1:0] a, input logic [2*N-1:0] b, input bit mx);
        int d [N+1][N+1];
        for (int i = 0; i <= N; i++) begin
            for (int j = 0; j <= N; j++) begin
                int best;
                bit have;
                have = 1'b0;
                best = 0;
                if (i == 0 && j == 0) begin
                    d[i][j] = 0;
                end else begin
                    if (i > 0) begin
                        best = d[i-1][j] + CD;
                        have = 1'b1;
                    end
                    if (j > 0) begin
                        int c = d[i][j-1] + CI;
                        if (!have || (mx ? c > best : c < best)) best = c;
                        have = 1'b1;
                    end
                    if (i > 0 && j > 0) begin
                        int c = d[i-1][j-1] + ((a[2*(i-1) +: 2] == b[2*(j-1) +: 2]) ? CM : CS);
                        if (mx ? c > best : c < best) best = c;
                    end
                    d[i][j] = best;
                end
            end
        end
        return d[N][N];
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // wait for done; returns number of edges after the start edge
    task automatic wait_done(output int lat);
        lat = 0;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic race(input logic [2*N-1:0] a, input logic [2*N-1:0] b, input bit mx,
                        input bit flip, input string req);
        int lat;
        int exp;
        @(negedge clk);
        str_a = a; str_b = b; mode_max = mx; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (flip) begin
            str_a = ~a; str_b = {b[1:0], b[2*N-1:2]}; mode_max = ~mx;
        end
        wait_done(lat);
        exp = ref_score(a, b, mx);
        chk(req, int'(score), exp);
        chk("R5 latency", lat, exp + 1);
        @(negedge clk);
        chk("R5 pulse", int'(done), 0);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed_v;
        int lat;
        logic [SW-1:0] held;
        seed_v = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6 reset done", int'(done), 0);
        chk("R6 reset score", int'(score), 0);

        // R3 worked example, minimise
        race(enc("ACGTGCA"), enc("CCTGCAA"), 1'b0, 1'b0, "R3 example min");
        // R4 same pair, maximise
        race(enc("ACGTGCA"), enc("CCTGCAA"), 1'b1, 1'b0, "R4 example max");
        // R2 identical strings -> all-match diagonal
        race(enc("GATTACA"), enc("GATTACA"), 1'b0, 1'b0, "R2 identical min");
        chk("R2 identical value", int'(score), N * CM);
        // R2 all different
        race(enc("AAAAAAA"), enc("CCCCCCC"), 1'b0, 1'b0, "R2 disjoint min");
        race(enc("TTTTTTT"), enc("GGGGGGG"), 1'b1, 1'b0, "R4 disjoint max");
        // R7 inputs flipped right after start
        race(enc("ACGTGCA"), enc("CCTGCAA"), 1'b0, 1'b1, "R7 ignore min");
        race(enc("CATGTAC"), enc("ACGGTTA"), 1'b1, 1'b1, "R7 ignore max");

        // R6 score holds without start
        held = score;
        str_a = enc("TTTTTTT"); mode_max = 1'b1;
        repeat (6) @(negedge clk);
        chk("R6 hold", int'(score), int'(held));

        // R1 relaunch during a race
        @(negedge clk);
        str_a = enc("AAAAAAA"); str_b = enc("TTTTTTT"); mode_max = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        str_a = enc("ACGTACG"); str_b = enc("ACGTACG"); mode_max = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(lat);
        chk("R1 relaunch score", int'(score), ref_score(enc("ACGTACG"), enc("ACGTACG"), 1'b0));
        chk("R1 relaunch latency", lat, ref_score(enc("ACGTACG"), enc("ACGTACG"), 1'b0) + 1);

        // R8 random strings in both modes through the gated bands
        for (int t = 0; t < 40; t++) begin
            logic [2*N-1:0] ra;
            logic [2*N-1:0] rb;
            ra = (2*N)'({$urandom(), $urandom()});
            rb = (2*N)'({$urandom(), $urandom()});
            race(ra, rb, 1'($urandom() & 1), 1'($urandom() & 1), "R8 random");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule